// File: doc/BRIEF.md
# Product-Term Array with Sharing

This block is the sum-of-products engine of one logic block in a programmable logic device. A wide input bus is expanded into true and complemented literals and fed to a programmable AND plane. Each AND-plane row forms one product term. The logic terms are taken in fixed clusters of five, one cluster per output. A sharing array then ORs each cluster into one output of its choice within a short wrap-around window. Any output can also skip the sharing array and take its own cluster directly. A few further rows form control product terms that are brought out on their own.

All configuration is held in flops and is written one word per clock through an address/data/write-enable port, normally before operation. Once loaded, every output is purely combinational from `term_in`. A write changes the configuration at the clock edge on which it is taken. Reset clears every configuration bit.

Top module: `pterm_share_top`

## Requirements
- R1: Each AND-plane row holds a literal mask of 2*N_IN bits. Bit 2i selects input i true and bit 2i+1 selects input i complemented. The row's product term is the AND of all its selected literals.
- R2: Address map. Addresses 0 to N_OUT*5-1 are logic rows. The next N_CTL addresses are control rows. Address N_OUT*5+N_CTL+k holds the steering word of cluster k: bits [2:0] are the offset and bit 3 is the bypass flag.
- R3: A row that selects both the true and the complement literal of any one input gives 0 for every input pattern.
- R4: A row with no literal selected gives 0.
- R5: Cluster k is the OR of product terms 5k to 5k+4. A cluster that is not bypassed and has offset d (0 to 6) is ORed into output (k-d) mod N_OUT, so the window wraps past index 0. Each output is the OR of the clusters steered to it, and 0 when no cluster is steered to it.
- R6: When output j has its bypass flag set, the output equals cluster j alone. Clusters steered toward output j are then ignored, and the steering offset of cluster j has no effect.
- R7: An offset of 7 parks the cluster, so it reaches no output.
- R8: Reset clears all configuration. Until the first write, every output and every control term is 0 for any input.
- R9: Control term m equals product term N_OUT*5+m and never feeds any sum output.
- R10: A write takes effect at the clock edge on which `cfg_we` is high. In the cycle before that edge the outputs still follow the old configuration. With `cfg_we` low, and for addresses beyond the map, nothing changes.
- R11: Seven clusters steered to one output form a single 35-term sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low reset, clears all configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Row or steering word address |
| cfg_data | input | 2*N_IN | Literal mask, or steering word in the low four bits |
| term_in | input | N_IN | Input bus to the AND plane |
| sop_out | output | N_OUT | Sum-of-products outputs |
| ctl_pt | output | N_CTL | Control product terms |

## Verification
Two things can meet in one cycle: a configuration write and the combinational evaluation of the row being written. The bench drives the inputs and a write of the same row together. It samples the output before the clock edge, where the old term must still show. It samples again after the edge, where the new term must show. A second collision, a bypassed output with a foreign cluster steered at it, is provoked in the fixed table configuration. It is judged by full-width output compares against hand-worked values, and then by random configurations compared against an independent software model.

// File: rtl/ptsa_pkg.sv
`timescale 1ns/1ps
package ptsa_pkg;

  // Index reached by stepping `step` places up from `base` on a ring of n.
  function automatic int wrap_idx(int base, int step, int n);
    return (base + step) % n;
  endfunction

  // Highest code of an offset field; reserved to park a cluster.
  function automatic int park_code(int off_w);
    return (1 << off_w) - 1;
  endfunction

endpackage

// File: rtl/pt_cfg_decode.sv
`timescale 1ns/1ps
module pt_cfg_decode #(
  parameter int N_ROWS  = 163,
  parameter int N_STEER = 32,
  parameter int AW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_addr,
  output logic [N_ROWS-1:0]  row_we,
  output logic [N_STEER-1:0] steer_we
);

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    assign row_we[r] = cfg_we && (cfg_addr == AW'(r));
  end

  for (genvar s = 0; s < N_STEER; s++) begin : g_steer
    assign steer_we[s] = cfg_we && (cfg_addr == AW'(N_ROWS + s));
  end

  // R10: one write reaches at most one storage word
  p_single_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({row_we, steer_we}));

  // R10: no strobe while the port is idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |-> ({row_we, steer_we} == '0));

endmodule

// File: rtl/pt_and_plane.sv
`timescale 1ns/1ps
module pt_and_plane #(
  parameter int N_IN   = 68,
  parameter int N_ROWS = 163
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_ROWS-1:0]   row_we,
  input  logic [2*N_IN-1:0]   cfg_data,
  input  logic [N_IN-1:0]     term_in,
  output logic [N_ROWS-1:0]   pt_out
);

  localparam int DW = 2 * N_IN;

  function automatic logic [DW-1:0] true_lanes();
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < N_IN; i++) m[2*i] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] TRUE_LANES = true_lanes();

  // Level of each literal: even lane true input, odd lane complement.
  logic [DW-1:0]     lit_level;
  logic [N_ROWS-1:0] row_empty;
  logic [N_ROWS-1:0] row_conflict;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit_level[2*i]   = term_in[i];
    assign lit_level[2*i+1] = ~term_in[i];
  end

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    logic [DW-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        row_q <= '0;
      else if (row_we[r]) row_q <= cfg_data;
    end

    assign row_empty[r]    = (row_q == '0);
    assign row_conflict[r] = |(row_q & (row_q >> 1) & TRUE_LANES);
    // A selected literal at level 0 kills the term.
    assign pt_out[r]       = ~row_empty[r] & ~|(row_q & ~lit_level);

    p_conflict_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      row_conflict[r] |-> !pt_out[r]);

    p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      row_empty[r] |-> !pt_out[r]);
  end

endmodule

// File: rtl/pt_share_array.sv
`timescale 1ns/1ps
module pt_share_array #(
  parameter int N_OUT = 32,
  parameter int CL    = 5,
  parameter int OFF_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_OUT-1:0]    steer_we,
  input  logic [OFF_W:0]      steer_data,
  input  logic [N_OUT*CL-1:0] pt_in,
  output logic [N_OUT-1:0]    sum_out
);

  localparam int SPAN = ptsa_pkg::park_code(OFF_W);
  localparam logic [OFF_W-1:0] PARK = OFF_W'(SPAN);

  logic [OFF_W-1:0] off_q [N_OUT];
  logic [N_OUT-1:0] byp_q;
  logic [N_OUT-1:0] clus;
  logic [N_OUT-1:0] parked;

  for (genvar k = 0; k < N_OUT; k++) begin : g_clus
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_q[k] <= '0;
        byp_q[k] <= 1'b0;
      end else if (steer_we[k]) begin
        off_q[k] <= steer_data[OFF_W-1:0];
        byp_q[k] <= steer_data[OFF_W];
      end
    end

    assign clus[k]   = |pt_in[k*CL +: CL];
    assign parked[k] = !byp_q[k] && (off_q[k] == PARK);
  end

  // Each output gathers from the clusters just above it on the ring.
  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic [SPAN-1:0] take;
    for (genvar d = 0; d < SPAN; d++) begin : g_win
      localparam int K = ptsa_pkg::wrap_idx(j, d, N_OUT);
      assign take[d] = clus[K] && !byp_q[K] && (off_q[K] == OFF_W'(d));
    end
    assign sum_out[j] = byp_q[j] ? clus[j] : |take;

    p_bypass_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
      byp_q[j] |-> (sum_out[j] == clus[j]));
  end

  p_parked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((byp_q == '0) && (&parked)) |-> (sum_out == '0));

  p_sum_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|sum_out) |-> (|clus));

endmodule

// File: rtl/pterm_share_top.sv
`timescale 1ns/1ps
module pterm_share_top #(
  parameter int N_IN   = 68,
  parameter int N_OUT  = 32,
  parameter int CL     = 5,
  parameter int N_CTL  = 3,
  parameter int OFF_W  = 3,
  parameter int ADDR_W = $clog2(N_OUT*CL + N_CTL + N_OUT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [2*N_IN-1:0]   cfg_data,
  input  logic [N_IN-1:0]     term_in,
  output logic [N_OUT-1:0]    sop_out,
  output logic [N_CTL-1:0]    ctl_pt
);

  localparam int N_LOG  = N_OUT * CL;
  localparam int N_ROWS = N_LOG + N_CTL;

  logic [N_ROWS-1:0] row_we;
  logic [N_OUT-1:0]  steer_we;
  logic [N_ROWS-1:0] pt_all;
  logic              fresh;

  pt_cfg_decode #(.N_ROWS(N_ROWS), .N_STEER(N_OUT), .AW(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .row_we(row_we), .steer_we(steer_we)
  );

  pt_and_plane #(.N_IN(N_IN), .N_ROWS(N_ROWS)) u_and (
    .clk(clk), .rst_n(rst_n), .row_we(row_we), .cfg_data(cfg_data),
    .term_in(term_in), .pt_out(pt_all)
  );

  pt_share_array #(.N_OUT(N_OUT), .CL(CL), .OFF_W(OFF_W)) u_share (
    .clk(clk), .rst_n(rst_n), .steer_we(steer_we),
    .steer_data(cfg_data[OFF_W:0]), .pt_in(pt_all[N_LOG-1:0]),
    .sum_out(sop_out)
  );

  assign ctl_pt = pt_all[N_ROWS-1:N_LOG];

  // High from reset until the first write is taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fresh <= 1'b1;
    else if (cfg_we) fresh <= 1'b0;
  end

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> ((sop_out == '0) && (ctl_pt == '0)));

endmodule

// File: tb/sim_pterm_share_top.sv
`timescale 1ns/1ps
module sim_pterm_share_top;
  localparam int NI = 68, NO = 32, CL = 5, NC = 3, OW = 3;
  localparam int NL = NO * CL, NR = NL + NC, NA = NR + NO;
  localparam int AW = $clog2(NA), DW = 2 * NI;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [DW-1:0] cfg_data;
  logic [NI-1:0] term_in;
  logic [NO-1:0] sop;
  logic [NC-1:0] ctl;

  pterm_share_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .term_in(term_in), .sop_out(sop), .ctl_pt(ctl)
  );

  int n_chk = 0, n_bad = 0;

  // Bench-side image of what has been written.
  logic [DW-1:0] m_row [NR];
  logic [OW-1:0] m_off [NO];
  logic          m_byp [NO];

  // Table: {in[10:0] at [17:7], in67 at [18]}, expected {o4,o30,o1,o0}, ctl.
  localparam logic [18:0] TBL [11] = '{
    {12'h000, 4'b0010, 3'b000}, {12'h003, 4'b0011, 3'b000},
    {12'h004, 4'b0000, 3'b000}, {12'h00C, 4'b0010, 3'b000},
    {12'h020, 4'b0110, 3'b000}, {12'h060, 4'b0010, 3'b000},
    {12'h800, 4'b0110, 3'b000}, {12'h500, 4'b0010, 3'b101},
    {12'h780, 4'b0010, 3'b001}, {12'hFFF, 4'b0111, 3'b001},
    {12'h001, 4'b0010, 3'b000}
  };

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lit(int i, bit neg);
    logic [DW-1:0] d;
    d = '0;
    d[2*i + (neg ? 1 : 0)] = 1'b1;
    return d;
  endfunction

  function automatic logic [DW-1:0] sw(int off, bit byp);
    logic [DW-1:0] d;
    d = '0;
    d[OW-1:0] = OW'(off);
    d[OW] = byp;
    return d;
  endfunction

  function automatic logic m_pt(int r, logic [NI-1:0] v);
    logic any, ok;
    any = 1'b0; ok = 1'b1;
    for (int i = 0; i < NI; i++) begin
      if (m_row[r][2*i])   begin any = 1'b1; if (!v[i]) ok = 1'b0; end
      if (m_row[r][2*i+1]) begin any = 1'b1; if (v[i])  ok = 1'b0; end
    end
    return any && ok;
  endfunction

  function automatic logic [NO-1:0] m_sop(logic [NI-1:0] v);
    logic [NO-1:0] o;
    logic c;
    int dst;
    o = '0;
    for (int k = 0; k < NO; k++) begin
      c = 1'b0;
      for (int t = 0; t < CL; t++) c = c | m_pt(k*CL + t, v);
      if (m_byp[k]) o[k] = o[k] | c;
      else if (int'(m_off[k]) != 7) begin
        dst = (k - int'(m_off[k]) + NO) % NO;
        if (!m_byp[dst]) o[dst] = o[dst] | c;
      end
    end
    return o;
  endfunction

  function automatic logic [NC-1:0] m_ctl(logic [NI-1:0] v);
    logic [NC-1:0] o;
    for (int m = 0; m < NC; m++) o[m] = m_pt(NL + m, v);
    return o;
  endfunction

  task automatic clear_model();
    for (int r = 0; r < NR; r++) m_row[r] = '0;
    for (int k = 0; k < NO; k++) begin m_off[k] = '0; m_byp[k] = 1'b0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0;
    clear_model();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < NR) m_row[a] = d;
    else if (a < NA) begin m_off[a-NR] = d[OW-1:0]; m_byp[a-NR] = d[OW]; end
  endtask

  task automatic model_chk(string tag, logic [NI-1:0] v);
    @(negedge clk);
    term_in = v;
    #1;
    chk({tag, " sop"}, 64'(sop), 64'(m_sop(v)));
    chk({tag, " ctl"}, 64'(ctl), 64'(m_ctl(v)));
  endtask

  task automatic load_cfg_a();
    wr(0,   lit(0,0) | lit(1,0));
    wr(5,   lit(2,1));
    wr(10,  lit(3,0));
    wr(15,  lit(5,0) | lit(6,1));
    wr(155, lit(67,0));
    wr(20,  lit(7,0) | lit(7,1));
    wr(30,  lit(0,0));
    wr(160, lit(8,0));
    wr(162, lit(9,1) | lit(10,0));
    wr(NR+0,  sw(1,1));
    wr(NR+2,  sw(1,0));
    wr(NR+3,  sw(5,0));
    wr(NR+6,  sw(6,0));
    wr(NR+31, sw(1,0));
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [NI-1:0] v;
    logic [NO-1:0] e;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0; term_in = '1;
    clear_model();
    repeat (3) @(negedge clk);
    #1;
    chk("R8 in reset sop", 64'(sop), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 after reset sop", 64'(sop), 64'h0);
    chk("R8 after reset ctl", 64'(ctl), 64'h0);

    // Table walk: R1 R2 R3 R5 R6 R9 on a fixed configuration
    load_cfg_a();
    for (int t = 0; t < 11; t++) begin
      v = '0;
      v[10:0] = TBL[t][17:7];
      v[67]   = TBL[t][18];
      e = '0;
      e[0] = TBL[t][3]; e[1] = TBL[t][4]; e[30] = TBL[t][5]; e[4] = TBL[t][6];
      @(negedge clk);
      term_in = v;
      #1;
      chk($sformatf("R5/R6 table %0d sop", t), 64'(sop), 64'(e));
      chk($sformatf("R9/R3 table %0d ctl", t), 64'(ctl), 64'(TBL[t][2:0]));
    end

    // R10: write and evaluation in one cycle
    v = '0; v[0] = 1'b1; v[1] = 1'b1;
    @(negedge clk);
    term_in = v;
    cfg_we = 1'b1; cfg_addr = AW'(0); cfg_data = '0;
    #1;
    chk("R10 old row before edge", 64'(sop[0]), 64'h1);
    @(negedge clk);
    cfg_we = 1'b0; m_row[0] = '0;
    #1;
    chk("R10 new row after edge", 64'(sop[0]), 64'h0);
    wr(0, lit(0,0) | lit(1,0));
    #1;
    chk("R10 row restored", 64'(sop[0]), 64'h1);

    // R10: strobe low means no write
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = AW'(0); cfg_data = '0;
    repeat (2) @(negedge clk);
    #1;
    chk("R10 idle port keeps row", 64'(sop[0]), 64'h1);

    // R10: address beyond the map
    wr(255, '1);
    @(negedge clk);
    term_in = '1;
    #1;
    chk("R10 out-of-map write ignored", 64'(sop), 64'h4000_0003);
    chk("R10 out-of-map ctl", 64'(ctl), 64'h1);

    // R7: park cluster 3
    wr(NR+3, sw(7,0));
    v = '0; v[5] = 1'b1;
    @(negedge clk);
    term_in = v;
    #1;
    chk("R7 parked cluster", 64'(sop), 64'h2);

    // R8: reset after configuration
    do_reset();
    @(negedge clk);
    term_in = '1;
    #1;
    chk("R8 reset clears sop", 64'(sop), 64'h0);
    chk("R8 reset clears ctl", 64'(ctl), 64'h0);

    // R11: 35 terms pooled into output 0
    for (int r = 0; r < 35; r++) wr(r, lit(r,0));
    for (int k = 1; k < 7; k++) wr(NR+k, sw(k,0));
    @(negedge clk);
    term_in = '0;
    #1;
    chk("R11 pooled idle", 64'(sop), 64'h0);
    foreach (TBL[q]) begin
      if (q < 3) begin
        v = '0; v[q*17] = 1'b1;
        @(negedge clk);
        term_in = v;
        #1;
        chk($sformatf("R11 pooled term %0d", q*17), 64'(sop), 64'h1);
      end
    end

    // Random configurations against the model: R1 R3 R4 R5 R6 R7 R9
    for (int c = 0; c < 12; c++) begin
      for (int r = 0; r < NR; r++) begin
        logic [DW-1:0] d;
        int nl;
        d = '0;
        nl = $urandom_range(0, 3);
        for (int n = 0; n < nl; n++) d = d | lit($urandom_range(0, NI-1), bit'($urandom_range(0,1)));
        wr(r, d);
      end
      for (int k = 0; k < NO; k++)
        wr(NR+k, sw($urandom_range(0,7), ($urandom_range(0,3) == 0)));
      for (int n = 0; n < 25; n++) begin
        logic [95:0] rv;
        rv = {$urandom(), $urandom(), $urandom()};
        model_chk($sformatf("R5 random cfg %0d vec %0d", c, n), rv[NI-1:0]);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule